// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block interprets bus write cycles aimed at a 16-bit parallel NOR flash that uses the classic unlock-then-command protocol. Each write carries a word address and a 16-bit data word. Only the low byte of the data is decoded as a command. The block tracks multi-write command sequences and moves between its operating modes: array read, identifier read, query-table read, single-word program and unlock-bypass. Reads return either a word from a small internal storage array or a fixed identifier or query response, one clock after the read request.

Programming can only clear bits, because the written word is ANDed into the stored word. Erase commands are decoded here, but the erase itself is timed by a separate erase engine. This block issues a one-cycle start pulse, a chip/sector flag and a sector index. While the engine reports busy, reads return the engine's status word, and command writes other than suspend and resume are ignored. When the engine signals completion, the selected words are filled with 0xFFFF.

The sequencer states are:
- Read (`S_READ`).
- First and second unlock (`S_UNL1`, `S_UNL2`).
- Program armed (`S_PROG`).
- Erase setup, erase unlock one and erase unlock two (`S_ERS1`, `S_ERS2`, `S_ERS3`).
- Identifier (`S_AUTO`).
- Query (`S_CFI`).
- Bypass idle (`S_BYP`).
- Bypass program armed (`S_BYP_PROG`).

The transitions are:
- Read to first unlock on 0xAA at key address 0x555.
- First unlock to second unlock on 0x55 at 0x2AA.
- From second unlock, on a write to 0x555: 0xA0 goes to program armed, 0x90 to identifier, 0x20 to bypass idle and 0x80 to erase setup.
- Program armed back to read on any write, which stores the data.
- Erase setup and its two unlock states repeat the 0xAA/0x55 unlock pair. The final write, 0x10 at 0x555 or 0x30 at any address, returns to read and starts the erase.
- Read or identifier to query on 0x98 at 0x55.
- Query back to read, or back to identifier if it was entered from there, on 0xF0.
- Identifier to read on 0xF0.
- Bypass idle to bypass program armed on 0xA0 at any address, and bypass program armed back to bypass idle on any write.
- Bypass idle to read on 0x00.
- Any mismatching write to read.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After reset the block is in read mode, rd_data is 0, erase_start/erase_suspend/erase_resume are low, and every array word reads 0xFFFF.
- R2: 0xAA at 0x555, 0x55 at 0x2AA, then 0xA0 at 0x555 arm a program. The next write ANDs its 16-bit data into the word at its address, so 0x0055 followed by 0x00A5 leaves 0x0005.
- R3: The unlock pair followed by 0x90 at 0x555 enters identifier mode. There, address 0 reads 0x00BF, address 1 reads 0x236D, and other addresses read 0.
- R4: 0x98 at address 0x55 enters query mode from read or identifier mode. Query offset 0x10 reads 0x0051, 0x11 reads 0x0052, 0x12 reads 0x0059, 0x27 reads log2 of the array size in bytes (7 by default) and 0x2C reads 1. A 0xF0 write returns to identifier mode if query was entered from identifier mode, and otherwise to read mode.
- R5: 0xF0 written at any address outside bypass, query and the armed states returns the block to read mode.
- R6: The unlock pair followed by 0x20 at 0x555 enters bypass. There, 0xA0 at any address arms a program with no unlock. 0x00 at any address exits bypass, and a program then attempted without unlock leaves the array unchanged.
- R7: Command address compares use only address bits 10:0, so 0x5555 and 0x2AAA act as 0x555 and 0x2AA.
- R8: The unlock pair, 0x80 at 0x555, the unlock pair again, then 0x10 at 0x555 or 0x30 at any address pulses erase_start for one cycle, in the cycle after that write. erase_chip is 1 for 0x10 and 0 for 0x30. erase_sector holds the sector index (address bits 5:4 by default). After erase_done the chip or that sector reads 0xFFFF and other sectors are unchanged.
- R9: A write with the wrong address or wrong data inside a sequence returns the block to read mode with no program and no erase.
- R10: While erase_busy is high, reads return erase_status and command writes do not change the mode or the array. A 0xB0 write pulses erase_suspend and a 0x30 write pulses erase_resume, each in the next cycle.
- R11: rd_data shows the addressed word one cycle after rd_en. If a read and a program hit the same word in the same cycle, the read returns the old word and a later read returns the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | AW (16) | Word address of the write |
| wr_data | input | 16 | Write data; low byte decoded as a command |
| rd_en | input | 1 | Bus read strobe |
| rd_addr | input | AW (16) | Word address of the read |
| rd_data | output | 16 | Read data, valid one cycle after rd_en |
| erase_busy | input | 1 | Erase engine busy |
| erase_status | input | 16 | Erase engine status word returned on reads while busy |
| erase_done | input | 1 | Erase completion pulse; fills the selected words with 0xFFFF |
| erase_start | output | 1 | One-cycle erase start pulse |
| erase_chip | output | 1 | 1 for chip erase, 0 for sector erase |
| erase_sector | output | SECW (2) | Sector index of a sector erase |
| erase_suspend | output | 1 | One-cycle suspend request |
| erase_resume | output | 1 | One-cycle resume request |

## Verification
A read and a program can land on the same array word in the same clock edge. The bench arms a program, then drives the data write and a read of the same address together. It expects the read to return the pre-program word 0xFFFF, and a following read to return the programmed value. A second overlap is a command write arriving while the erase engine is busy. The bench issues a full program sequence and an identifier sequence under busy, then confirms after busy drops that the array word and the read mode are both unchanged.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

    typedef enum logic [3:0] {
        S_READ,
        S_UNL1,
        S_UNL2,
        S_PROG,
        S_ERS1,
        S_ERS2,
        S_ERS3,
        S_AUTO,
        S_CFI,
        S_BYP,
        S_BYP_PROG
    } cmd_state_t;

    typedef enum logic [1:0] {
        RM_ARRAY,
        RM_ID,
        RM_CFI
    } rd_mode_t;

    localparam logic [7:0] C_KEY_A     = 8'hAA;
    localparam logic [7:0] C_KEY_B     = 8'h55;
    localparam logic [7:0] C_PROGRAM   = 8'hA0;
    localparam logic [7:0] C_IDENT     = 8'h90;
    localparam logic [7:0] C_QUERY     = 8'h98;
    localparam logic [7:0] C_RETURN    = 8'hF0;
    localparam logic [7:0] C_ERASE_SET = 8'h80;
    localparam logic [7:0] C_CHIP_ERS  = 8'h10;
    localparam logic [7:0] C_SECT_ERS  = 8'h30;
    localparam logic [7:0] C_BYP_ON    = 8'h20;
    localparam logic [7:0] C_BYP_OFF   = 8'h00;
    localparam logic [7:0] C_SUSPEND   = 8'hB0;

    localparam logic [10:0] A_KEY0  = 11'h555;
    localparam logic [10:0] A_KEY1  = 11'h2AA;
    localparam logic [10:0] A_QUERY = 11'h055;

    localparam logic [15:0] ID_MFR = 16'h00BF;
    localparam logic [15:0] ID_DEV = 16'h236D;

endpackage

// File: rtl/nor_seq_fsm.sv
module nor_seq_fsm
    import nor_cmd_pkg::*;
#(
    parameter int SECW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [10:0]     key_addr,
    input  logic [7:0]      cmd,
    input  logic [SECW-1:0] sector_in,
    input  logic            erase_busy,
    output rd_mode_t        rd_mode,
    output logic            prog_en,
    output logic            ers_fire,
    output logic            ers_chip,
    output logic            erase_start,
    output logic            erase_chip,
    output logic [SECW-1:0] erase_sector,
    output logic            erase_suspend,
    output logic            erase_resume
);

    cmd_state_t state, nxt;
    logic       cfi_ret, nxt_ret;
    logic       susp_fire, res_fire;
    logic       at_key0, at_key1, at_query;

    assign at_key0  = (key_addr == A_KEY0);
    assign at_key1  = (key_addr == A_KEY1);
    assign at_query = (key_addr == A_QUERY);

    always_comb begin
        nxt       = state;
        nxt_ret   = cfi_ret;
        prog_en   = 1'b0;
        ers_fire  = 1'b0;
        ers_chip  = 1'b0;
        susp_fire = 1'b0;
        res_fire  = 1'b0;
        if (wr_en) begin
            if (erase_busy) begin
                if (cmd == C_SUSPEND)
                    susp_fire = 1'b1;
                else if (cmd == C_SECT_ERS)
                    res_fire = 1'b1;
            end else begin
                unique case (state)
                    S_READ: begin
                        if (at_key0 && cmd == C_KEY_A)
                            nxt = S_UNL1;
                        else if (at_query && cmd == C_QUERY) begin
                            nxt     = S_CFI;
                            nxt_ret = 1'b0;
                        end else
                            nxt = S_READ;
                    end
                    S_UNL1: nxt = (at_key1 && cmd == C_KEY_B) ? S_UNL2 : S_READ;
                    S_UNL2: begin
                        nxt = S_READ;
                        if (at_key0) begin
                            unique case (cmd)
                                C_PROGRAM:   nxt = S_PROG;
                                C_IDENT:     nxt = S_AUTO;
                                C_BYP_ON:    nxt = S_BYP;
                                C_ERASE_SET: nxt = S_ERS1;
                                default:     nxt = S_READ;
                            endcase
                        end
                    end
                    S_PROG: begin
                        prog_en = 1'b1;
                        nxt     = S_READ;
                    end
                    S_ERS1: nxt = (at_key0 && cmd == C_KEY_A) ? S_ERS2 : S_READ;
                    S_ERS2: nxt = (at_key1 && cmd == C_KEY_B) ? S_ERS3 : S_READ;
                    S_ERS3: begin
                        nxt = S_READ;
                        if (at_key0 && cmd == C_CHIP_ERS) begin
                            ers_fire = 1'b1;
                            ers_chip = 1'b1;
                        end else if (cmd == C_SECT_ERS) begin
                            ers_fire = 1'b1;
                        end
                    end
                    S_AUTO: begin
                        if (cmd == C_RETURN)
                            nxt = S_READ;
                        else if (at_query && cmd == C_QUERY) begin
                            nxt     = S_CFI;
                            nxt_ret = 1'b1;
                        end
                    end
                    S_CFI: begin
                        if (cmd == C_RETURN)
                            nxt = cfi_ret ? S_AUTO : S_READ;
                    end
                    S_BYP: begin
                        if (cmd == C_PROGRAM)
                            nxt = S_BYP_PROG;
                        else if (cmd == C_BYP_OFF)
                            nxt = S_READ;
                    end
                    S_BYP_PROG: begin
                        prog_en = 1'b1;
                        nxt     = S_BYP;
                    end
                    default: nxt = S_READ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (state)
            S_AUTO:  rd_mode = RM_ID;
            S_CFI:   rd_mode = RM_CFI;
            default: rd_mode = RM_ARRAY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_READ;
            cfi_ret <= 1'b0;
        end else begin
            state   <= nxt;
            cfi_ret <= nxt_ret;
        end
    end

    // registered outputs to the erase engine
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            erase_start   <= 1'b0;
            erase_chip    <= 1'b0;
            erase_sector  <= '0;
            erase_suspend <= 1'b0;
            erase_resume  <= 1'b0;
        end else begin
            erase_start   <= ers_fire;
            erase_suspend <= susp_fire;
            erase_resume  <= res_fire;
            if (ers_fire) begin
                erase_chip   <= ers_chip;
                erase_sector <= ers_chip ? '0 : sector_in;
            end
        end
    end

    // R8
    ers_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |-> ($past(wr_en) && !$past(erase_busy)));

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_busy |=> (state == $past(state)));

    // R10
    susp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_suspend || erase_resume) |-> ($past(erase_busy) && $past(wr_en)));

    // R4
    cfi_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CFI && $past(state) != S_CFI) |-> ($past(cmd) == C_QUERY && $past(wr_en)));

    // R8
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({erase_start, erase_suspend, erase_resume}));

endmodule

// File: rtl/nor_word_array.sv
module nor_word_array #(
    parameter int DEPTH   = 64,
    parameter int SECTORS = 4,
    localparam int IDXW   = $clog2(DEPTH),
    localparam int SECW   = $clog2(SECTORS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            prog_en,
    input  logic [IDXW-1:0] prog_idx,
    input  logic [15:0]     prog_data,
    input  logic            ers_fire,
    input  logic            ers_chip,
    input  logic [SECW-1:0] ers_sector,
    input  logic            erase_done,
    input  logic [IDXW-1:0] rd_idx,
    output logic [15:0]     rd_word
);

    localparam int SEC_WORDS = DEPTH / SECTORS;

    logic [15:0]     mem [DEPTH];
    logic            pend_chip;
    logic [SECW-1:0] pend_sec;

    assign rd_word = mem[rd_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_chip <= 1'b0;
            pend_sec  <= '0;
        end else if (ers_fire) begin
            pend_chip <= ers_chip;
            pend_sec  <= ers_sector;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= 16'hFFFF;
        end else if (erase_done) begin
            for (int i = 0; i < DEPTH; i++)
                if (pend_chip || (SECW'(i / SEC_WORDS) == pend_sec))
                    mem[i] <= 16'hFFFF;
        end else if (prog_en) begin
            mem[prog_idx] <= mem[prog_idx] & prog_data;
        end
    end

    // R2
    prog_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_en && !erase_done) |=> ((mem[$past(prog_idx)] & ~$past(mem[prog_idx])) == 16'h0));

endmodule

// File: rtl/nor_read_port.sv
module nor_read_port
    import nor_cmd_pkg::*;
#(
    parameter int SIZE_LOG2 = 7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rd_en,
    input  logic [7:0]  rd_off,
    input  rd_mode_t    rd_mode,
    input  logic        erase_busy,
    input  logic [15:0] erase_status,
    input  logic [15:0] arr_word,
    output logic [15:0] rd_data
);

    logic [15:0] id_word, cfi_word, sel_word;

    always_comb begin
        unique case (rd_off)
            8'h00:   id_word = ID_MFR;
            8'h01:   id_word = ID_DEV;
            default: id_word = 16'h0;
        endcase
    end

    always_comb begin
        unique case (rd_off)
            8'h10:   cfi_word = 16'h0051;
            8'h11:   cfi_word = 16'h0052;
            8'h12:   cfi_word = 16'h0059;
            8'h27:   cfi_word = 16'(SIZE_LOG2);
            8'h2C:   cfi_word = 16'h0001;
            default: cfi_word = 16'h0;
        endcase
    end

    always_comb begin
        if (erase_busy)
            sel_word = erase_status;
        else begin
            unique case (rd_mode)
                RM_ID:   sel_word = id_word;
                RM_CFI:  sel_word = cfi_word;
                default: sel_word = arr_word;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rd_data <= 16'h0;
        else if (rd_en)
            rd_data <= sel_word;
    end

    // R11
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
    import nor_cmd_pkg::*;
#(
    parameter int AW      = 16,
    parameter int DEPTH   = 64,
    parameter int SECTORS = 4,
    localparam int IDXW   = $clog2(DEPTH),
    localparam int SECW   = $clog2(SECTORS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [15:0]     wr_data,
    input  logic            rd_en,
    input  logic [AW-1:0]   rd_addr,
    output logic [15:0]     rd_data,
    input  logic            erase_busy,
    input  logic [15:0]     erase_status,
    input  logic            erase_done,
    output logic            erase_start,
    output logic            erase_chip,
    output logic [SECW-1:0] erase_sector,
    output logic            erase_suspend,
    output logic            erase_resume
);

    localparam int SIZE_LOG2 = $clog2(DEPTH * 2);

    rd_mode_t    rd_mode;
    logic        prog_en, ers_fire, ers_chip;
    logic [15:0] arr_word;

    nor_seq_fsm #(.SECW(SECW)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .key_addr     (wr_addr[10:0]),
        .cmd          (wr_data[7:0]),
        .sector_in    (wr_addr[IDXW-1 -: SECW]),
        .erase_busy   (erase_busy),
        .rd_mode      (rd_mode),
        .prog_en      (prog_en),
        .ers_fire     (ers_fire),
        .ers_chip     (ers_chip),
        .erase_start  (erase_start),
        .erase_chip   (erase_chip),
        .erase_sector (erase_sector),
        .erase_suspend(erase_suspend),
        .erase_resume (erase_resume)
    );

    nor_word_array #(.DEPTH(DEPTH), .SECTORS(SECTORS)) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .prog_en    (prog_en),
        .prog_idx   (wr_addr[IDXW-1:0]),
        .prog_data  (wr_data),
        .ers_fire   (ers_fire),
        .ers_chip   (ers_chip),
        .ers_sector (wr_addr[IDXW-1 -: SECW]),
        .erase_done (erase_done),
        .rd_idx     (rd_addr[IDXW-1:0]),
        .rd_word    (arr_word)
    );

    nor_read_port #(.SIZE_LOG2(SIZE_LOG2)) u_rd (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_en        (rd_en),
        .rd_off       (rd_addr[7:0]),
        .rd_mode      (rd_mode),
        .erase_busy   (erase_busy),
        .erase_status (erase_status),
        .arr_word     (arr_word),
        .rd_data      (rd_data)
    );

endmodule

// File: tb/nor_cmd_decoder_test.sv
module nor_cmd_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_addr = '0;
    logic [15:0] rd_data;
    logic        erase_busy = 1'b0;
    logic [15:0] erase_status = '0;
    logic        erase_done = 1'b0;
    logic        erase_start, erase_chip, erase_suspend, erase_resume;
    logic [1:0]  erase_sector;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    nor_cmd_decoder uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .erase_busy(erase_busy), .erase_status(erase_status), .erase_done(erase_done),
        .erase_start(erase_start), .erase_chip(erase_chip), .erase_sector(erase_sector),
        .erase_suspend(erase_suspend), .erase_resume(erase_resume)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [15:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic unlock();
        wr(16'h555, 16'h00AA);
        wr(16'h2AA, 16'h0055);
    endtask

    task automatic program_word(input logic [15:0] a, input logic [15:0] d);
        unlock();
        wr(16'h555, 16'h00A0);
        wr(a, d);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        check("R1 rd_data", rd_data, 16'h0);
        check("R1 start", {13'h0, erase_start, erase_suspend, erase_resume}, 16'h0);
        rd(16'd0, v);  check("R1 word0", v, 16'hFFFF);
        rd(16'd63, v); check("R1 word63", v, 16'hFFFF);
    endtask

    task automatic t_program();
        logic [15:0] v;
        program_word(16'd5, 16'h0055);
        rd(16'd5, v); check("R2 first", v, 16'h0055);
        program_word(16'd5, 16'h00A5);
        rd(16'd5, v); check("R2 and", v, 16'h0005);
    endtask

    task automatic t_ident();
        logic [15:0] v;
        unlock();
        wr(16'h555, 16'h0090);
        rd(16'd0, v); check("R3 mfr", v, 16'h00BF);
        rd(16'd1, v); check("R3 dev", v, 16'h236D);
        rd(16'd2, v); check("R3 other", v, 16'h0000);
        wr(16'h1234, 16'h00F0);
        rd(16'd5, v); check("R5 back to array", v, 16'h0005);
    endtask

    task automatic t_query();
        logic [15:0] v;
        wr(16'h055, 16'h0098);
        rd(16'h10, v); check("R4 Q", v, 16'h0051);
        rd(16'h11, v); check("R4 R", v, 16'h0052);
        rd(16'h12, v); check("R4 Y", v, 16'h0059);
        rd(16'h27, v); check("R4 size", v, 16'h0007);
        rd(16'h2C, v); check("R4 regions", v, 16'h0001);
        wr(16'h0, 16'h00F0);
        rd(16'd5, v); check("R4 exit to array", v, 16'h0005);
        unlock();
        wr(16'h555, 16'h0090);
        wr(16'h055, 16'h0098);
        rd(16'h10, v); check("R4 Q from ident", v, 16'h0051);
        wr(16'h0, 16'h00F0);
        rd(16'h0, v); check("R4 exit to ident", v, 16'h00BF);
        wr(16'h0, 16'h00F0);
        rd(16'h0, v); check("R5 array", v, 16'hFFFF);
    endtask

    task automatic t_alias();
        logic [15:0] v;
        wr(16'h5555, 16'h00AA);
        wr(16'h2AAA, 16'h0055);
        wr(16'h5555, 16'h0090);
        rd(16'h0, v); check("R7 alias ident", v, 16'h00BF);
        wr(16'h0, 16'h00F0);
    endtask

    task automatic t_break();
        logic [15:0] v;
        wr(16'h555, 16'h00AA);
        wr(16'h2AB, 16'h0055);
        wr(16'h555, 16'h00A0);
        wr(16'd7, 16'h0000);
        rd(16'd7, v); check("R9 bad addr", v, 16'hFFFF);
        unlock();
        wr(16'h555, 16'h0077);
        wr(16'd7, 16'h0000);
        rd(16'd7, v); check("R9 bad data", v, 16'hFFFF);
    endtask

    task automatic t_bypass();
        logic [15:0] v;
        unlock();
        wr(16'h555, 16'h0020);
        wr(16'h555, 16'h00A0); wr(16'd0, 16'h0001);
        wr(16'd3, 16'h00A0);   wr(16'd3, 16'h0067);
        wr(16'd0, 16'h0000);
        wr(16'h555, 16'h00A0); wr(16'd4, 16'h0089);
        rd(16'd0, v); check("R6 word0", v, 16'h0001);
        rd(16'd3, v); check("R6 any-addr arm", v, 16'h0067);
        rd(16'd4, v); check("R6 after exit ignored", v, 16'hFFFF);
    endtask

    task automatic t_erase();
        logic [15:0] v;
        program_word(16'd20, 16'h0000);
        unlock();
        wr(16'h555, 16'h0080);
        unlock();
        wr(16'd20, 16'h0030);
        check("R8 start", {15'h0, erase_start}, 16'h1);
        check("R8 chip flag", {15'h0, erase_chip}, 16'h0);
        check("R8 sector", {14'h0, erase_sector}, 16'h1);
        @(negedge clk);
        check("R8 one cycle", {15'h0, erase_start}, 16'h0);
        erase_busy = 1'b1; erase_status = 16'h1234;
        rd(16'd3, v); check("R10 status", v, 16'h1234);
        program_word(16'd5, 16'h0000);
        unlock();
        wr(16'h555, 16'h0090);
        wr(16'h0, 16'h00B0);
        check("R10 suspend", {15'h0, erase_suspend}, 16'h1);
        wr(16'h0, 16'h0030);
        check("R10 resume", {15'h0, erase_resume}, 16'h1);
        check("R10 no start", {15'h0, erase_start}, 16'h0);
        @(negedge clk);
        erase_done = 1'b1;
        @(negedge clk);
        erase_done = 1'b0; erase_busy = 1'b0;
        rd(16'd20, v); check("R8 sector filled", v, 16'hFFFF);
        rd(16'd3, v);  check("R8 other sector kept", v, 16'h0067);
        rd(16'd5, v);  check("R10 program ignored", v, 16'h0005);
        rd(16'd1, v);  check("R10 ident ignored", v, 16'hFFFF);
        unlock();
        wr(16'h555, 16'h0080);
        unlock();
        wr(16'h555, 16'h0010);
        check("R8 chip start", {15'h0, erase_start}, 16'h1);
        check("R8 chip flag set", {15'h0, erase_chip}, 16'h1);
        @(negedge clk);
        erase_done = 1'b1;
        @(negedge clk);
        erase_done = 1'b0;
        rd(16'd3, v);  check("R8 chip word3", v, 16'hFFFF);
        rd(16'd5, v);  check("R8 chip word5", v, 16'hFFFF);
    endtask

    task automatic t_collide();
        logic [15:0] v;
        unlock();
        wr(16'h555, 16'h00A0);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 16'd9; wr_data = 16'h00F0;
        rd_en = 1'b1; rd_addr = 16'd9;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check("R11 old word", rd_data, 16'hFFFF);
        rd(16'd9, v); check("R11 new word", v, 16'h00F0);
    endtask

    initial begin
        #(4 * 20000);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program();
        t_ident();
        t_query();
        t_alias();
        t_break();
        t_bypass();
        t_erase();
        t_collide();
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule